// File: doc/BRIEF.md
# Masked Bit-Test Condition Evaluator

This unit looks at the bits of a 64-bit operand picked out by a 64-bit selector mask and reduces them to a 2-bit condition code. It is purely combinational. The code depends on the operand, the mask and a 2-bit mode, and it settles in the same cycle as its inputs. The block that issues the instruction feeds it the operand and the mask, and it latches the code wherever its flags live. Carrying out an insert or writing back a register is left to other logic.

There are three modes. Two are test modes: a narrow one that uses only the low half of both words, and a wide one that uses all 64 bits. The third is an insert mode, which describes the bits that an insert under the same mask would deliver.

All three modes tell apart "nothing selected is set" and the mixed case. The two test modes also flag "everything selected is set". In the mixed case the wide test mode and the insert mode look at the operand bit that sits under the highest set bit of the mask. They map that bit to opposite codes. A leading-one priority encoder on the mask finds that position.

There are no data transfers, so the unit has no valid/ready handshake and no back-pressure. Its inputs are plain control and status levels that the caller holds for as long as it wants the code.

Top module: `tum_cond_eval`

## Requirements
- R1: In mode 0 (narrow test) or mode 1 (wide test), when the bitwise AND of operand and mask is zero, cc_o is 0.
- R2: In mode 0 or mode 1, when the mask is nonzero and the operand has every masked bit set, cc_o is 3.
- R3: In mode 1 with mixed masked bits, cc_o is 2 if the operand bit at the mask's highest set bit is 1, and 1 if that bit is 0.
- R4: In mode 0 with mixed masked bits, cc_o is 1, whatever the position of the mask's highest set bit.
- R5: In mode 0, bits 63..32 of both the operand and the mask have no effect on cc_o.
- R6: In mode 2 (insert), when the bitwise AND of operand and mask is zero, cc_o is 0.
- R7: In mode 2, when at least one masked bit is set, cc_o is 1 if the operand bit at the mask's highest set bit is 1, and 2 if it is 0. cc_o is never 3 in this mode.
- R8: An all-zero mask yields cc_o = 0 in modes 0, 1 and 2.
- R9: Mode 3 is reserved and always yields cc_o = 0.
- R10: cc_o is a combinational function of the present inputs, with no cycle of latency.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| mode_i | input | 2 | 0 narrow test, 1 wide test, 2 insert, 3 reserved |
| value_i | input | 64 | Operand whose bits are examined |
| mask_i | input | 64 | Selector mask; a 1 marks an examined bit |
| cc_o | output | 2 | Resulting condition code |

## Verification
Some directed operands make every masked bit zero and others make every masked bit one. Each is tried in all four modes, which separates the "none" and "all" outcomes and shows that the insert mode has no "all" code. Mixed patterns move the highest mask bit around the word, with the operand bit under it set and then cleared. This shows whether the encoder picks the highest mask bit rather than a lower one, and whether the wide test mode and the insert mode map that bit to opposite codes. A further set of patterns puts only noise in the upper half under the narrow test mode, to show that the upper half is ignored. Random operands and masks, both dense and sparse, are then compared with a behavioural model on every clock.

// File: rtl/tum_pkg.sv
package tum_pkg;
  typedef enum logic [1:0] {
    MODE_TEST_NARROW = 2'd0,
    MODE_TEST_WIDE   = 2'd1,
    MODE_INSERT      = 2'd2,
    MODE_RESERVED    = 2'd3
  } tum_mode_e;

  localparam logic [1:0] CC_NONE  = 2'd0;
  localparam logic [1:0] CC_LOW   = 2'd1;
  localparam logic [1:0] CC_HIGH  = 2'd2;
  localparam logic [1:0] CC_ALL   = 2'd3;
endpackage

// File: rtl/tum_lead_one.sv
module tum_lead_one #(
  parameter int W = 64,
  localparam int IDX_W = $clog2(W)
) (
  input  logic [W-1:0]     vec_i,
  output logic [IDX_W-1:0] pos_o,
  output logic             found_o
);
  always_comb begin
    pos_o   = '0;
    found_o = 1'b0;
    for (int i = 0; i < W; i++) begin
      if (vec_i[i]) begin
        pos_o   = IDX_W'(i);
        found_o = 1'b1;
      end
    end
  end

  always_comb begin
    // R3
    lead_pos_chk: assert (!found_o || ((vec_i >> pos_o) == W'(1)))
      else $error("leading-one position does not mark the top set bit");
  end
endmodule

// File: rtl/tum_sel_class.sv
module tum_sel_class #(
  parameter int W = 64
) (
  input  logic [W-1:0] value_i,
  input  logic [W-1:0] mask_i,
  output logic         none_o,
  output logic         all_o
);
  logic [W-1:0] picked;

  always_comb begin
    picked = value_i & mask_i;
    none_o = (picked == '0);
    all_o  = (picked == mask_i);
  end
endmodule

// File: rtl/tum_cc_map.sv
module tum_cc_map
  import tum_pkg::*;
(
  input  tum_mode_e  mode_i,
  input  logic       none_i,
  input  logic       all_i,
  input  logic       lead_bit_i,
  output logic [1:0] cc_o
);
  always_comb begin
    cc_o = CC_NONE;
    unique case (mode_i)
      MODE_TEST_NARROW: begin
        if (none_i)     cc_o = CC_NONE;
        else if (all_i) cc_o = CC_ALL;
        else            cc_o = CC_LOW;
      end
      MODE_TEST_WIDE: begin
        if (none_i)          cc_o = CC_NONE;
        else if (all_i)      cc_o = CC_ALL;
        else if (lead_bit_i) cc_o = CC_HIGH;
        else                 cc_o = CC_LOW;
      end
      MODE_INSERT: begin
        if (none_i)          cc_o = CC_NONE;
        else if (lead_bit_i) cc_o = CC_LOW;
        else                 cc_o = CC_HIGH;
      end
      default: cc_o = CC_NONE;
    endcase
  end

  always_comb begin
    // R7
    insert_no_all_chk: assert (mode_i != MODE_INSERT || cc_o != CC_ALL)
      else $error("insert mode produced the all-ones code");
    // R4
    narrow_no_high_chk: assert (mode_i != MODE_TEST_NARROW || cc_o != CC_HIGH)
      else $error("narrow test produced code 2");
  end
endmodule

// File: rtl/tum_cond_eval.sv
module tum_cond_eval
  import tum_pkg::*;
#(
  parameter int DATA_W = 64,
  localparam int HALF_W = DATA_W / 2,
  localparam int IDX_W  = $clog2(DATA_W)
) (
  input  logic [1:0]        mode_i,
  input  logic [DATA_W-1:0] value_i,
  input  logic [DATA_W-1:0] mask_i,
  output logic [1:0]        cc_o
);
  tum_mode_e         mode;
  logic [DATA_W-1:0] value_eff;
  logic [DATA_W-1:0] mask_eff;
  logic [IDX_W-1:0]  lead_pos;
  logic              lead_found;
  logic              sel_none;
  logic              sel_all;
  logic              lead_bit;

  always_comb begin
    mode = tum_mode_e'(mode_i);
    if (mode == MODE_TEST_NARROW) begin
      value_eff = {{HALF_W{1'b0}}, value_i[HALF_W-1:0]};
      mask_eff  = {{HALF_W{1'b0}}, mask_i[HALF_W-1:0]};
    end else begin
      value_eff = value_i;
      mask_eff  = mask_i;
    end
  end

  tum_lead_one #(.W(DATA_W)) u_lead (
    .vec_i   (mask_eff),
    .pos_o   (lead_pos),
    .found_o (lead_found)
  );

  tum_sel_class #(.W(DATA_W)) u_class (
    .value_i (value_eff),
    .mask_i  (mask_eff),
    .none_o  (sel_none),
    .all_o   (sel_all)
  );

  assign lead_bit = lead_found & value_eff[lead_pos];

  tum_cc_map u_map (
    .mode_i     (mode),
    .none_i     (sel_none),
    .all_i      (sel_all),
    .lead_bit_i (lead_bit),
    .cc_o       (cc_o)
  );

  always_comb begin
    // R8
    zero_mask_chk: assert (mask_i != '0 || cc_o == CC_NONE)
      else $error("zero mask gave a nonzero code");
    // R9
    rsv_mode_chk: assert (mode_i != 2'd3 || cc_o == CC_NONE)
      else $error("reserved mode gave a nonzero code");
    // R2
    test_all_chk: assert (!(mode_i inside {2'd0, 2'd1}) || !lead_found
                          || !sel_all || cc_o == CC_ALL)
      else $error("all masked bits set but code is not 3");
  end
endmodule

// File: tb/test_tum_cond_eval.sv
module test_tum_cond_eval;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [1:0]  mode;
  logic [63:0] val;
  logic [63:0] msk;
  logic [1:0]  cc;
  int total = 0;
  int bad = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  tum_cond_eval i_tum_cond_eval (
    .mode_i (mode), .value_i (val), .mask_i (msk), .cc_o (cc)
  );

  function automatic logic [1:0] model(input logic [1:0] md,
                                       input logic [63:0] v,
                                       input logic [63:0] m);
    logic [63:0] vv, mm, r;
    int top;
    vv = v; mm = m;
    if (md == 2'd3) return 2'd0;
    if (md == 2'd0) begin vv = {32'd0, v[31:0]}; mm = {32'd0, m[31:0]}; end
    r = vv & mm;
    if (r == 0) return 2'd0;
    top = -1;
    for (int i = 63; i >= 0; i--) if (mm[i] && top < 0) top = i;
    if (md == 2'd2) return vv[top] ? 2'd1 : 2'd2;
    if (r == mm) return 2'd3;
    if (md == 2'd0) return 2'd1;
    return vv[top] ? 2'd2 : 2'd1;
  endfunction

  task automatic apply(input logic [1:0] md, input logic [63:0] v,
                       input logic [63:0] m, input string req);
    logic [1:0] exp;
    @(negedge clk);
    mode = md; val = v; msk = m;
    exp = model(md, v, m);
    #1;  // R10: code settles in the same cycle, no clock edge in between
    total++;
    if (cc !== exp) begin
      bad++;
      $display("FAIL %s mode=%0d v=%h m=%h actual=%0d expected=%0d",
               req, md, v, m, cc, exp);
    end
  endtask

  task automatic expect_cc(input logic [1:0] md, input logic [63:0] v,
                           input logic [63:0] m, input logic [1:0] want,
                           input string req);
    @(negedge clk);
    mode = md; val = v; msk = m;
    #1;
    total++;
    if (cc !== want) begin
      bad++;
      $display("FAIL %s mode=%0d v=%h m=%h actual=%0d expected=%0d",
               req, md, v, m, cc, want);
    end
  endtask

  initial begin
    mode = 2'd0; val = '0; msk = '0;
    repeat (3) @(posedge clk);
    rst = 1'b0;
    expect_cc(2'd0, 64'd0, 64'd0, 2'd0, "R8 reset state");
    // R1 none selected
    expect_cc(2'd0, 64'hFFFF_0000_FFFF_0000, 64'h0000_0000_0000_FFFF, 2'd0, "R1");
    expect_cc(2'd1, 64'h00FF_FFFF_FFFF_FFFF, 64'hFF00_0000_0000_0000, 2'd0, "R1");
    // R2 all selected
    expect_cc(2'd0, 64'h0000_0000_F0F0_F0F0, 64'h0000_0000_F0F0_0000, 2'd3, "R2");
    expect_cc(2'd1, 64'hFFFF_FFFF_FFFF_FFFF, 64'h8000_0000_0000_0001, 2'd3, "R2");
    // R3 wide mixed, top mask bit set/clear in operand
    expect_cc(2'd1, 64'h8000_0000_0000_0000, 64'h8000_0000_0000_0001, 2'd2, "R3");
    expect_cc(2'd1, 64'h0000_0000_0000_0001, 64'h8000_0000_0000_0001, 2'd1, "R3");
    expect_cc(2'd1, 64'h0000_0400_0000_0000, 64'h0000_0700_0000_0000, 2'd2, "R3");
    expect_cc(2'd1, 64'h0000_0300_0000_0000, 64'h0000_0700_0000_0000, 2'd1, "R3");
    // R4 narrow mixed always 1
    expect_cc(2'd0, 64'h0000_0000_8000_0000, 64'h0000_0000_8000_0001, 2'd1, "R4");
    expect_cc(2'd0, 64'h0000_0000_0000_0001, 64'h0000_0000_8000_0001, 2'd1, "R4");
    // R5 upper half ignored in narrow mode
    expect_cc(2'd0, 64'hFFFF_FFFF_0000_0000, 64'hFFFF_FFFF_0000_0000, 2'd0, "R5");
    expect_cc(2'd0, 64'h1234_5678_0000_000F, 64'hFFFF_FFFF_0000_000F, 2'd3, "R5");
    expect_cc(2'd0, 64'h0000_0000_0000_0003, 64'h8000_0000_0000_0003, 2'd3, "R5");
    // R6 insert none
    expect_cc(2'd2, 64'hFFFF_FFFF_0FFF_FFFF, 64'h0000_0000_F000_0000, 2'd0, "R6");
    // R7 insert mixed and all-ones
    expect_cc(2'd2, 64'hFFFF_FFFF_FFFF_FFFF, 64'h0000_0000_0000_FF00, 2'd1, "R7");
    expect_cc(2'd2, 64'h0000_0000_0000_7F00, 64'h0000_0000_0000_FF00, 2'd2, "R7");
    expect_cc(2'd2, 64'h8000_0000_0000_0000, 64'h8000_0000_0000_0000, 2'd1, "R7");
    // R8 zero mask in every mode
    for (int md = 0; md < 3; md++)
      expect_cc(2'(md), 64'hFFFF_FFFF_FFFF_FFFF, 64'd0, 2'd0, "R8");
    // R9 reserved mode
    expect_cc(2'd3, 64'hFFFF_FFFF_FFFF_FFFF, 64'hFFFF_FFFF_FFFF_FFFF, 2'd0, "R9");
    expect_cc(2'd3, 64'h8000_0000_0000_0000, 64'hC000_0000_0000_0000, 2'd0, "R9");
    // Random sweep against the model, dense and sparse masks
    for (int n = 0; n < 2000; n++) begin
      logic [63:0] v, m;
      v = {$urandom, $urandom};
      m = {$urandom, $urandom};
      if (n % 2 == 1) m = m & {$urandom, $urandom} & {$urandom, $urandom};
      if (n % 7 == 0) v = v | m;
      apply(2'(n % 4), v, m, "R3/R7 random");
    end
    done = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      total++;
      bad++;
      $display("FAIL R10 watchdog expired actual=hung expected=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule